// File: doc/BRIEF.md
# Operand-Gated Complex Multiplier Lane

This block is one lane of a complex multiply-accumulate array. It holds a single complex weight in registers and multiplies every incoming complex sample by it, producing a full-precision complex product each clock. The weight is written during a load phase and then stays fixed while samples stream through. With the weight, the lane also stores two flag bits, one for each part. A flag says that part's magnitude is below the weight threshold. Every sample arrives with two matching flags, computed upstream against the input threshold.

The product is built from four real multipliers. Each multiplier has its own operand register. When power saving is enabled and both operands feeding a multiplier are flagged as small, that multiplier's operand register does not load. Its product register is also left unchanged. The adder stage then takes zero in place of that partial product. The result is an approximate product with far less switching when most operands are small. With power saving off, the product is exact.

Top module: `cmlane_top`

## Requirements
- R1: A synchronous active-high `rst` clears the stored weight, the flags, every pipeline register and both outputs. Both outputs read zero after the first clock edge with `rst` high.
- R2: A sample captured at a rising edge where `load_w` is low appears on `p_re`/`p_im` after the second rising edge that follows the capture edge. Samples at other cycles do not disturb that result.
- R3: With `save_pwr` low, `p_re` equals yR·wR − yI·wI and `p_im` equals yR·wI + yI·wR. The operands are signed two's complement of DW bits. The results are signed with 2·DW+1 bits and are never rounded or wrapped, including when operands take the most negative value.
- R4: A rising edge with `load_w` high stores `w_re`, `w_im`, `w_re_small` and `w_im_small`. While `load_w` is low, changes on those four inputs have no effect on the products or on the muting.
- R5: The four multipliers are numbered 0 to 3. Multiplier 0 forms yR·wR and uses flags y_re_small and stored w_re_small. Multiplier 1 forms yI·wI and uses y_im_small and stored w_im_small. Multiplier 2 forms yR·wI and uses y_re_small and stored w_im_small. Multiplier 3 forms yI·wR and uses y_im_small and stored w_re_small. A multiplier is muted for a sample when `save_pwr` is high and both of its flags are 1. While muted, its operand register holds its previous value.
- R6: A muted multiplier adds exactly zero to its output part. The unmuted partial products of the same sample are still summed exactly. When all four are muted, both outputs are zero.
- R7: With `save_pwr` low, no multiplier is muted, whatever the flag values. The same holds with `save_pwr` high for any multiplier that has at least one of its two flags at 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst | input | 1 | Synchronous reset, active high |
| load_w | input | 1 | Weight write strobe |
| w_re | input | DW | Weight real part, signed |
| w_im | input | DW | Weight imaginary part, signed |
| w_re_small | input | 1 | Weight real part below its threshold |
| w_im_small | input | 1 | Weight imaginary part below its threshold |
| y_re | input | DW | Sample real part, signed |
| y_im | input | DW | Sample imaginary part, signed |
| y_re_small | input | 1 | Sample real part below its threshold |
| y_im_small | input | 1 | Sample imaginary part below its threshold |
| save_pwr | input | 1 | Enables operand gating |
| p_re | output | 2*DW+1 | Product real part, signed, registered |
| p_im | output | 2*DW+1 | Product imaginary part, signed, registered |

## Verification
Streams with power saving off and every flag set show that flags alone never gate anything. Most-negative operand pairs show that the full output width carries 2^(2·DW−1) without wrapping. All sixteen combinations of stored weight flags and sample flags are applied with power saving on. Because the weight parts differ, each combination leaves a distinct sum, so every multiplier's gating term is told apart from the others. Further streams toggle the weight inputs while no load is taking place, and place an isolated nonzero sample among zeros. These separate the stored weight from the live weight bus and confirm the exact output cycle.

// File: rtl/cmlane_pkg.sv
package cmlane_pkg;
  localparam int NMULT = 4;
  // bit k set: multiplier k takes the imaginary part of the sample
  localparam logic [NMULT-1:0] Y_IM_SEL = 4'b1010;
  // bit k set: multiplier k takes the imaginary part of the weight
  localparam logic [NMULT-1:0] W_IM_SEL = 4'b0110;
endpackage

// File: rtl/cmlane_wstore.sv
module cmlane_wstore #(
  parameter int DW = 12
) (
  input  logic                 clk,
  input  logic                 rst,
  input  logic                 load,
  input  logic signed [DW-1:0] d_re,
  input  logic signed [DW-1:0] d_im,
  input  logic                 d_fre,
  input  logic                 d_fim,
  output logic signed [DW-1:0] q_re,
  output logic signed [DW-1:0] q_im,
  output logic                 q_fre,
  output logic                 q_fim
);
  always_ff @(posedge clk) begin
    if (rst) begin
      q_re  <= '0;
      q_im  <= '0;
      q_fre <= 1'b0;
      q_fim <= 1'b0;
    end else if (load) begin
      q_re  <= d_re;
      q_im  <= d_im;
      q_fre <= d_fre;
      q_fim <= d_fim;
    end
  end
endmodule

// File: rtl/cmlane_opgate.sv
module cmlane_opgate #(
  parameter int DW = 12
) (
  input  logic                 clk,
  input  logic                 rst,
  input  logic signed [DW-1:0] y_in,
  input  logic                 mute,
  output logic signed [DW-1:0] a_q,
  output logic                 mute_q
);
  always_ff @(posedge clk) begin
    if (rst) begin
      a_q    <= '0;
      mute_q <= 1'b0;
    end else begin
      mute_q <= mute;
      if (!mute) a_q <= y_in;
    end
  end
endmodule

// File: rtl/cmlane_gmul.sv
module cmlane_gmul #(
  parameter int DW = 12,
  localparam int PW = 2 * DW
) (
  input  logic                 clk,
  input  logic                 rst,
  input  logic signed [DW-1:0] a,
  input  logic signed [DW-1:0] w,
  input  logic                 mute,
  output logic signed [PW-1:0] term
);
  logic signed [PW-1:0] ax, wx, prod_q;
  logic                 mute_d;

  assign ax = {{DW{a[DW-1]}}, a};
  assign wx = {{DW{w[DW-1]}}, w};

  always_ff @(posedge clk) begin
    if (rst) begin
      prod_q <= '0;
      mute_d <= 1'b0;
    end else begin
      mute_d <= mute;
      if (!mute) prod_q <= ax * wx;
    end
  end

  // zero select in front of the adder for a frozen multiplier
  assign term = mute_d ? '0 : prod_q;
endmodule

// File: rtl/cmlane_sum.sv
module cmlane_sum #(
  parameter int PW = 24,
  localparam int SW = PW + 1
) (
  input  logic                 clk,
  input  logic                 rst,
  input  logic signed [PW-1:0] t0,
  input  logic signed [PW-1:0] t1,
  input  logic signed [PW-1:0] t2,
  input  logic signed [PW-1:0] t3,
  output logic signed [SW-1:0] s_re,
  output logic signed [SW-1:0] s_im
);
  logic signed [SW-1:0] x0, x1, x2, x3;

  assign x0 = {t0[PW-1], t0};
  assign x1 = {t1[PW-1], t1};
  assign x2 = {t2[PW-1], t2};
  assign x3 = {t3[PW-1], t3};

  always_ff @(posedge clk) begin
    if (rst) begin
      s_re <= '0;
      s_im <= '0;
    end else begin
      s_re <= x0 - x1;
      s_im <= x2 + x3;
    end
  end
endmodule

// File: rtl/cmlane_top.sv
module cmlane_top
  import cmlane_pkg::*;
#(
  parameter int DW = 12,
  localparam int PW = 2 * DW,
  localparam int OW = PW + 1
) (
  input  logic                 clk,
  input  logic                 rst,
  input  logic                 load_w,
  input  logic signed [DW-1:0] w_re,
  input  logic signed [DW-1:0] w_im,
  input  logic                 w_re_small,
  input  logic                 w_im_small,
  input  logic signed [DW-1:0] y_re,
  input  logic signed [DW-1:0] y_im,
  input  logic                 y_re_small,
  input  logic                 y_im_small,
  input  logic                 save_pwr,
  output logic signed [OW-1:0] p_re,
  output logic signed [OW-1:0] p_im
);
  logic signed [DW-1:0]        wq_re, wq_im;
  logic                        wf_re, wf_im;
  logic [NMULT-1:0]            mute_now, mute_reg;
  logic [NMULT-1:0][DW-1:0]    op_q;
  logic [NMULT-1:0][PW-1:0]    term;

  cmlane_wstore #(.DW(DW)) u_wst (
    .clk   (clk),
    .rst   (rst),
    .load  (load_w),
    .d_re  (w_re),
    .d_im  (w_im),
    .d_fre (w_re_small),
    .d_fim (w_im_small),
    .q_re  (wq_re),
    .q_im  (wq_im),
    .q_fre (wf_re),
    .q_fim (wf_im)
  );

  for (genvar k = 0; k < NMULT; k++) begin : g_mul
    logic signed [DW-1:0] y_sel, w_sel;
    logic                 fy, fw;

    assign y_sel = Y_IM_SEL[k] ? y_im : y_re;
    assign fy    = Y_IM_SEL[k] ? y_im_small : y_re_small;
    assign w_sel = W_IM_SEL[k] ? wq_im : wq_re;
    assign fw    = W_IM_SEL[k] ? wf_im : wf_re;
    assign mute_now[k] = save_pwr & fy & fw;

    cmlane_opgate #(.DW(DW)) u_op (
      .clk    (clk),
      .rst    (rst),
      .y_in   (y_sel),
      .mute   (mute_now[k]),
      .a_q    (op_q[k]),
      .mute_q (mute_reg[k])
    );

    cmlane_gmul #(.DW(DW)) u_mul (
      .clk  (clk),
      .rst  (rst),
      .a    (op_q[k]),
      .w    (w_sel),
      .mute (mute_reg[k]),
      .term (term[k])
    );
  end

  cmlane_sum #(.PW(PW)) u_sum (
    .clk  (clk),
    .rst  (rst),
    .t0   (term[0]),
    .t1   (term[1]),
    .t2   (term[2]),
    .t3   (term[3]),
    .s_re (p_re),
    .s_im (p_im)
  );
endmodule

// File: rtl/cmlane_chk.sv
module cmlane_chk #(
  parameter int DW = 12,
  localparam int OW = 2 * DW + 1
) (
  input logic                 clk,
  input logic                 rst,
  input logic                 load_w,
  input logic                 save_pwr,
  input logic [DW-1:0]        wq_re,
  input logic [DW-1:0]        wq_im,
  input logic                 wf_re,
  input logic                 wf_im,
  input logic [3:0]           mute_now,
  input logic [3:0]           mute_reg,
  input logic [3:0][DW-1:0]   op_q,
  input logic [OW-1:0]        p_re,
  input logic [OW-1:0]        p_im
);
  // R1
  rst_clear_chk: assert property (@(posedge clk)
    rst |=> (p_re == '0 && p_im == '0 && mute_reg == '0));

  // R4
  weight_hold_chk: assert property (@(posedge clk) disable iff (rst)
    !load_w |=> ($stable(wq_re) && $stable(wq_im) && $stable(wf_re) && $stable(wf_im)));

  // R5
  for (genvar k = 0; k < 4; k++) begin : g_frz
    operand_freeze_chk: assert property (@(posedge clk) disable iff (rst)
      mute_now[k] |=> $stable(op_q[k]));
  end

  // R6
  all_muted_zero_chk: assert property (@(posedge clk) disable iff (rst)
    (&mute_reg) |=> ##1 (p_re == '0 && p_im == '0));

  // R7
  no_save_no_mute_chk: assert property (@(posedge clk) disable iff (rst)
    !save_pwr |=> (mute_reg == '0));
endmodule

bind cmlane_top cmlane_chk #(.DW(DW)) u_chk (
  .clk      (clk),
  .rst      (rst),
  .load_w   (load_w),
  .save_pwr (save_pwr),
  .wq_re    (wq_re),
  .wq_im    (wq_im),
  .wf_re    (wf_re),
  .wf_im    (wf_im),
  .mute_now (mute_now),
  .mute_reg (mute_reg),
  .op_q     (op_q),
  .p_re     (p_re),
  .p_im     (p_im)
);

// File: tb/tb_cmlane_top.sv
`timescale 1ns/1ps
module tb_cmlane_top;
  localparam int DW = 12;
  localparam int OW = 2 * DW + 1;
  localparam int MINV = -(1 << (DW - 1));
  localparam int MAXV = (1 << (DW - 1)) - 1;

  logic                 clk = 1'b0;
  logic                 rst = 1'b1;
  logic                 load_w = 1'b0;
  logic signed [DW-1:0] w_re = '0, w_im = '0, y_re = '0, y_im = '0;
  logic                 w_re_small = 1'b0, w_im_small = 1'b0;
  logic                 y_re_small = 1'b0, y_im_small = 1'b0;
  logic                 save_pwr = 1'b0;
  logic signed [OW-1:0] p_re, p_im;

  int n_chk = 0;
  int n_fail = 0;
  bit done = 0;

  // bench copy of the stored weight, built from R4
  longint bw_re = 0, bw_im = 0;
  bit     bf_re = 0, bf_im = 0;

  // expected results waiting for their output cycle (R2: three steps later)
  bit     hv[3];
  longint he_re[3], he_im[3];
  string  htag[3];
  int     mute_cnt[4];

  always #5 clk = ~clk;

  cmlane_top #(.DW(DW)) dut (
    .clk(clk), .rst(rst), .load_w(load_w),
    .w_re(w_re), .w_im(w_im), .w_re_small(w_re_small), .w_im_small(w_im_small),
    .y_re(y_re), .y_im(y_im), .y_re_small(y_re_small), .y_im_small(y_im_small),
    .save_pwr(save_pwr), .p_re(p_re), .p_im(p_im)
  );

  task automatic check(input bit ok, input string tag, input longint ar, input longint ai,
                       input longint er, input longint ei);
    n_chk++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s: actual (%0d,%0d) expected (%0d,%0d)", tag, ar, ai, er, ei);
    end
  endtask

  // one cycle: check the result due now, then drive the next inputs
  task automatic step(input bit lw, input int wr, input int wi, input bit fwr, input bit fwi,
                      input int yr, input int yi, input bit fyr, input bit fyi,
                      input bit sp, input string tag);
    bit m0, m1, m2, m3;
    longint a_r, a_i, er, ei;
    @(negedge clk);
    if (hv[2]) check(longint'(p_re) == he_re[2] && longint'(p_im) == he_im[2], htag[2],
                     longint'(p_re), longint'(p_im), he_re[2], he_im[2]);
    hv[2] = hv[1]; he_re[2] = he_re[1]; he_im[2] = he_im[1]; htag[2] = htag[1];
    hv[1] = hv[0]; he_re[1] = he_re[0]; he_im[1] = he_im[0]; htag[1] = htag[0];
    load_w = lw; save_pwr = sp;
    w_re = DW'(wr); w_im = DW'(wi); w_re_small = fwr; w_im_small = fwi;
    y_re = DW'(yr); y_im = DW'(yi); y_re_small = fyr; y_im_small = fyi;
    a_r = longint'(y_re); a_i = longint'(y_im);
    m0 = sp & fyr & bf_re;
    m1 = sp & fyi & bf_im;
    m2 = sp & fyr & bf_im;
    m3 = sp & fyi & bf_re;
    if (!lw) begin
      mute_cnt[0] += int'(m0); mute_cnt[1] += int'(m1);
      mute_cnt[2] += int'(m2); mute_cnt[3] += int'(m3);
    end
    er = (m0 ? 0 : a_r * bw_re) - (m1 ? 0 : a_i * bw_im);
    ei = (m2 ? 0 : a_r * bw_im) + (m3 ? 0 : a_i * bw_re);
    hv[0] = !lw; he_re[0] = er; he_im[0] = ei; htag[0] = tag;
    if (lw) begin
      bw_re = longint'(w_re); bw_im = longint'(w_im); bf_re = fwr; bf_im = fwi;
    end
  endtask

  task automatic load(input int wr, input int wi, input bit fwr, input bit fwi);
    step(1, wr, wi, fwr, fwi, 0, 0, 0, 0, 0, "load");
  endtask

  task automatic flush();
    for (int i = 0; i < 3; i++) step(0, 0, 0, 0, 0, 0, 0, 0, 0, 0, "flush R2");
  endtask

  task automatic t_reset();
    @(negedge clk);
    check(p_re == '0 && p_im == '0, "R1 reset outputs", longint'(p_re), longint'(p_im), 0, 0);
  endtask

  task automatic t_exact();
    load(37, -501, 1, 1);
    for (int i = 0; i < 10; i++)
      step(0, 0, 0, 0, 0, (i * 379) % 2000 - 1000, 700 - i * 151, 1, 1, 0, "R7 flags set, save off");
    for (int i = 0; i < 6; i++)
      step(0, 0, 0, 0, 0, i * 97 - 300, -i * 211, i[0], i[1], 0, "R3 exact product");
    flush();
  endtask

  task automatic t_extreme();
    load(MINV, MINV, 0, 0);
    step(0, 0, 0, 0, 0, MINV, MINV, 0, 0, 0, "R3 min*min");
    step(0, 0, 0, 0, 0, MAXV, MINV, 0, 0, 0, "R3 max/min");
    step(0, 0, 0, 0, 0, MINV, MAXV, 0, 0, 0, "R3 min/max");
    flush();
    load(MINV, MAXV, 0, 0);
    step(0, 0, 0, 0, 0, MINV, MINV, 0, 0, 0, "R3 min weight re, max weight im");
    step(0, 0, 0, 0, 0, MAXV, MAXV, 0, 0, 0, "R3 max operands");
    flush();
  endtask

  task automatic t_gating();
    for (int wf = 0; wf < 4; wf++) begin
      load(113, -29, wf[0], wf[1]);
      for (int yf = 0; yf < 4; yf++) begin
        step(0, 0, 0, 0, 0, 301 + yf * 17, -457 + wf * 5, yf[0], yf[1], 1, "R5 R6 gating combo");
        step(0, 0, 0, 0, 0, -88 - yf, 640, yf[0], yf[1], 1, "R5 R6 gating repeat");
      end
      step(0, 0, 0, 0, 0, 999, -999, 0, 0, 1, "R7 save on, sample flags clear");
    end
    flush();
    load(5, 7, 1, 1);
    step(0, 0, 0, 0, 0, 1500, -1500, 1, 1, 1, "R6 all muted");
    step(0, 0, 0, 0, 0, 1200, 300, 1, 1, 1, "R6 all muted hold");
    step(0, 0, 0, 0, 0, -1, 2, 0, 0, 1, "R5 release after freeze");
    flush();
    check(mute_cnt[0] > 0 && mute_cnt[1] > 0 && mute_cnt[2] > 0 && mute_cnt[3] > 0,
          "R5 every multiplier muted at least once", mute_cnt[0], mute_cnt[1], 1, 1);
  endtask

  task automatic t_hold();
    load(-77, 19, 1, 0);
    for (int i = 0; i < 8; i++)
      step(0, i * 300 - 1200, MAXV - i, i[0], i[1], 250 - i * 40, 90 + i * 33, 1, 1, 1,
           "R4 weight bus ignored while streaming");
    flush();
  endtask

  task automatic t_latency();
    load(3, 4, 0, 0);
    step(0, 0, 0, 0, 0, 0, 0, 0, 0, 0, "R2 zero before pulse");
    step(0, 0, 0, 0, 0, 10, -20, 0, 0, 0, "R2 pulse");
    step(0, 0, 0, 0, 0, 0, 0, 0, 0, 0, "R2 zero after pulse");
    step(0, 0, 0, 0, 0, 0, 0, 0, 0, 0, "R2 zero after pulse 2");
    flush();
  endtask

  initial begin
    for (int i = 0; i < 3; i++) hv[i] = 0;
    for (int i = 0; i < 4; i++) mute_cnt[i] = 0;
    repeat (3) @(posedge clk);
    t_reset();
    rst = 1'b0;
    t_exact();
    t_extreme();
    t_gating();
    t_hold();
    t_latency();
    if (!done) begin
      done = 1;
      $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
      $finish;
    end
  end

  initial begin
    #1000000;
    if (!done) begin
      done = 1;
      n_chk++;
      n_fail++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
      $finish;
    end
  end
endmodule